// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. When paging is switched on, it fetches a directory entry and then a page table entry over a single memory port, and joins the final frame number with the byte offset. When paging is off, the linear address comes back unchanged after one cycle and memory is never touched. Every lookup ends in a one-cycle done strobe. The strobe carries either a physical address or a page fault flag.

While the walk runs, the walker keeps usage flags in memory up to date. It marks each entry it uses as accessed, and it marks the final entry as dirty when the access is a write. It does this by writing the entry back to the address it was read from, and only when a bit actually changes. A lookup stops with a fault as soon as an entry at either level is not present. Such an entry is never written.

The memory port carries one transaction at a time under a valid/ready handshake. A read finishes when its response arrives. A write finishes at its handshake.

Top module: `pgwalk_top`

## Requirements
- R1: With `pg_enable` low when a request is accepted, `rsp_done` rises in the next cycle with `rsp_phys` equal to the accepted linear address, `rsp_fault` low, and no memory request issued.
- R2: With paging on, the first memory request is a read at `{dir_base[31:12], lin[31:22], 2'b00}`. `dir_base` and `lin` are taken at acceptance, so later changes to the inputs have no effect.
- R3: The page table entry is read at `{pde[31:12], lin[21:12], 2'b00}`, where `pde` is the directory entry that was read.
- R4: On success, `rsp_phys = {pte[31:12], lin[11:0]}` and `rsp_fault` is low.
- R5: If the directory entry has bit 0 (present) clear, the walk ends with `rsp_fault` high and `rsp_phys` zero. No further memory request is made, and that entry is not written, whatever its other bits hold.
- R6: If the page table entry has bit 0 clear, the walk ends with a fault and `rsp_phys` zero, and that entry is not written.
- R7: If a present directory entry has bit 5 (accessed) clear, the walker writes `pde | 32'h20` back to the same address before it reads the table. Directory bit 6 is never changed, even on a write access.
- R8: A present page table entry is written back as `pte | 32'h20`, with `32'h40` (dirty, bit 6) also set when the request has `req_write` high. Both bits go out in the same single write.
- R9: A write-back is issued only when it changes the entry. It always targets the address of the read just before it. No other memory requests occur.
- R10: `mem_req_valid`, `mem_req_we`, `mem_req_addr` and `mem_req_wdata` stay constant while a request waits for `mem_req_ready`. A read waits for `mem_rsp_valid` before the walk continues.
- R11: `req_ready` is high only when the walker is idle. Memory requests occur only while the walker is busy. `rsp_done` lasts exactly one cycle and is followed by idle. `rsp_fault` is low whenever `rsp_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken on valid and ready |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write (sets dirty in the final entry) |
| pg_enable | input | 1 | Paging on; when low the address passes through |
| dir_base | input | 32 | Physical base of the page directory (bits 31:12 used) |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_phys | output | 32 | Physical address, valid with `rsp_done` |
| rsp_fault | output | 1 | Not-present fault, valid with `rsp_done` |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | Request is a write-back |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
The accessed and dirty updates of the final entry can fall due in the same write cycle. This case is provoked by a write access to a page whose entry has both bits clear. It is judged by requiring exactly one write-back that carries `32'h60` on top of the old value, with no second write.

The directory-level accessed update can also share a lookup with a write access. That case is judged by checking that the directory write leaves bit 6 as read. Memory ready stalls and response latency are varied around these cases, so that held requests and delayed data overlap the update cycles.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // Entry flag positions decoded by the walker
  localparam int unsigned BIT_PRESENT  = 0;
  localparam int unsigned BIT_ACCESSED = 5;
  localparam int unsigned BIT_DIRTY    = 6;

  // Number of table levels walked
  localparam int unsigned NUM_LVL = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WAIT,
    ST_DIR_CHK,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WAIT,
    ST_TBL_CHK,
    ST_TBL_WB,
    ST_DONE
  } walk_st_e;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32
) (
  input  logic [ADDR_W-1:0]        lin,
  input  logic [ADDR_W-OFF_W-1:0]  base_frame,
  input  logic [ADDR_W-OFF_W-1:0]  dir_frame,
  input  logic [ADDR_W-OFF_W-1:0]  leaf_frame,
  output logic [ADDR_W-1:0]        dir_ent_addr,
  output logic [ADDR_W-1:0]        tbl_ent_addr,
  output logic [ADDR_W-1:0]        leaf_phys
);
  localparam int ENT_SH  = $clog2(ENTRY_W / 8);
  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int TBL_LSB = OFF_W;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;

  assign dir_idx = lin[DIR_LSB +: IDX_W];
  assign tbl_idx = lin[TBL_LSB +: IDX_W];

  // Entry address = table frame, index scaled by entry size
  assign dir_ent_addr = {base_frame, dir_idx, {ENT_SH{1'b0}}};
  assign tbl_ent_addr = {dir_frame,  tbl_idx, {ENT_SH{1'b0}}};
  assign leaf_phys    = {leaf_frame, lin[OFF_W-1:0]};

endmodule

// File: rtl/pgwalk_entry.sv
module pgwalk_entry
  import pgwalk_pkg::*;
#(
  parameter int ENTRY_W = 32,
  parameter bit LEAF    = 1'b0
) (
  input  logic [ENTRY_W-1:0] ent,
  input  logic               is_write,
  output logic               present,
  output logic               wb_need,
  output logic [ENTRY_W-1:0] wb_data
);
  localparam logic [ENTRY_W-1:0] A_MASK = ENTRY_W'(1) << BIT_ACCESSED;
  localparam logic [ENTRY_W-1:0] D_MASK = ENTRY_W'(1) << BIT_DIRTY;

  logic [ENTRY_W-1:0] set_mask;

  generate
    if (LEAF) begin : g_leaf
      // Final level: accessed always, dirty on write
      assign set_mask = A_MASK | (is_write ? D_MASK : '0);
    end else begin : g_dir
      // Directory level: accessed only, dirty left as read
      logic unused_wr;
      assign unused_wr = is_write;
      assign set_mask  = A_MASK;
    end
  endgenerate

  assign present = ent[BIT_PRESENT];
  assign wb_data = ent | set_mask;
  assign wb_need = present && (wb_data != ent);

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_lin,
  input  logic                      req_write,
  input  logic                      pg_enable,
  input  logic [ADDR_W-OFF_W-1:0]   base_frame_in,
  output logic [ADDR_W-1:0]         lin_q,
  output logic                      wr_q,
  output logic [ADDR_W-OFF_W-1:0]   base_frame_q,
  output logic [ENTRY_W-1:0]        ent_q,
  output logic [ADDR_W-OFF_W-1:0]   pde_frame_q,
  input  logic [ADDR_W-1:0]         dir_ent_addr,
  input  logic [ADDR_W-1:0]         tbl_ent_addr,
  input  logic [ADDR_W-1:0]         leaf_phys,
  input  logic [NUM_LVL-1:0]        present,
  input  logic [NUM_LVL-1:0]        wb_need,
  input  logic [ENTRY_W-1:0]        wb_data_dir,
  input  logic [ENTRY_W-1:0]        wb_data_tbl,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_req_we,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic [ENTRY_W-1:0]        mem_req_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [ENTRY_W-1:0]        mem_rsp_rdata,
  output logic                      rsp_done,
  output logic [ADDR_W-1:0]         rsp_phys,
  output logic                      rsp_fault
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  walk_st_e          state_q, state_d;
  logic              lin_en, ent_en, pde_en, res_en;
  logic [ADDR_W-1:0] res_phys_d, res_phys_q;
  logic              res_fault_d, res_fault_q;

  // ---------------- next state ----------------
  always_comb begin
    state_d     = state_q;
    lin_en      = 1'b0;
    ent_en      = 1'b0;
    pde_en      = 1'b0;
    res_en      = 1'b0;
    res_phys_d  = '0;
    res_fault_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          lin_en = 1'b1;
          if (pg_enable) begin
            state_d = ST_DIR_RD;
          end else begin
            state_d    = ST_DONE;
            res_en     = 1'b1;
            res_phys_d = req_lin;
          end
        end
      end
      ST_DIR_RD:   if (mem_req_ready) state_d = ST_DIR_WAIT;
      ST_DIR_WAIT: begin
        if (mem_rsp_valid) begin
          ent_en  = 1'b1;
          state_d = ST_DIR_CHK;
        end
      end
      ST_DIR_CHK: begin
        if (!present[0]) begin
          res_en      = 1'b1;
          res_fault_d = 1'b1;
          state_d     = ST_DONE;
        end else begin
          pde_en  = 1'b1;
          state_d = wb_need[0] ? ST_DIR_WB : ST_TBL_RD;
        end
      end
      ST_DIR_WB:   if (mem_req_ready) state_d = ST_TBL_RD;
      ST_TBL_RD:   if (mem_req_ready) state_d = ST_TBL_WAIT;
      ST_TBL_WAIT: begin
        if (mem_rsp_valid) begin
          ent_en  = 1'b1;
          state_d = ST_TBL_CHK;
        end
      end
      ST_TBL_CHK: begin
        res_en = 1'b1;
        if (!present[1]) begin
          res_fault_d = 1'b1;
          state_d     = ST_DONE;
        end else begin
          res_phys_d = leaf_phys;
          state_d    = wb_need[1] ? ST_TBL_WB : ST_DONE;
        end
      end
      ST_TBL_WB:   if (mem_req_ready) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (lin_en) begin
      lin_q        <= req_lin;
      wr_q         <= req_write;
      base_frame_q <= base_frame_in;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= mem_rsp_rdata;
  end

  always_ff @(posedge clk) begin
    if (pde_en) pde_frame_q <= ent_q[ENTRY_W-1 -: FRAME_W];
  end

  always_ff @(posedge clk) begin
    if (res_en) begin
      res_phys_q  <= res_phys_d;
      res_fault_q <= res_fault_d;
    end
  end

  // ---------------- outputs ----------------
  logic in_dir, in_wb;
  assign in_dir        = (state_q == ST_DIR_RD) || (state_q == ST_DIR_WB);
  assign in_wb         = (state_q == ST_DIR_WB) || (state_q == ST_TBL_WB);
  assign mem_req_valid = in_dir || in_wb || (state_q == ST_TBL_RD);
  assign mem_req_we    = in_wb;
  assign mem_req_addr  = in_dir ? dir_ent_addr : tbl_ent_addr;
  assign mem_req_wdata = (state_q == ST_DIR_WB) ? wb_data_dir : wb_data_tbl;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = (state_q == ST_DONE);
  assign rsp_phys  = res_phys_q;
  assign rsp_fault = rsp_done && res_fault_q;

  // ---------------- assertions ----------------
  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) // R10
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) // R11
    rsp_done |=> !rsp_done && req_ready);

  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n) // R1
    req_valid && req_ready && !pg_enable |=> rsp_done && !rsp_fault && (rsp_phys == $past(req_lin)));

  AST_WAIT_FOR_DATA: assert property (@(posedge clk) disable iff (!rst_n) // R10
    mem_req_valid && mem_req_ready && !mem_req_we |=> !mem_req_valid && !rsp_done);

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              req_write,
  input  logic              pg_enable,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_rdata
);
  localparam int ENTRY_W = ADDR_W;
  localparam int FRAME_W = ADDR_W - OFF_W;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic unused_base;
  assign unused_base = ^dir_base[OFF_W-1:0];

  logic [ADDR_W-1:0]  lin_q;
  logic               wr_q;
  logic [FRAME_W-1:0] base_frame_q;
  logic [ENTRY_W-1:0] ent_q;
  logic [FRAME_W-1:0] pde_frame_q;
  logic [ADDR_W-1:0]  dir_ent_addr, tbl_ent_addr, leaf_phys;
  logic [NUM_LVL-1:0] present, wb_need;
  logic [ENTRY_W-1:0] wb_data [NUM_LVL];

  pgwalk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_lin       (req_lin),
    .req_write     (req_write),
    .pg_enable     (pg_enable),
    .base_frame_in (dir_base[ADDR_W-1:OFF_W]),
    .lin_q         (lin_q),
    .wr_q          (wr_q),
    .base_frame_q  (base_frame_q),
    .ent_q         (ent_q),
    .pde_frame_q   (pde_frame_q),
    .dir_ent_addr  (dir_ent_addr),
    .tbl_ent_addr  (tbl_ent_addr),
    .leaf_phys     (leaf_phys),
    .present       (present),
    .wb_need       (wb_need),
    .wb_data_dir   (wb_data[0]),
    .wb_data_tbl   (wb_data[1]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .rsp_done      (rsp_done),
    .rsp_phys      (rsp_phys),
    .rsp_fault     (rsp_fault)
  );

  pgwalk_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)) u_addr (
    .lin          (lin_q),
    .base_frame   (base_frame_q),
    .dir_frame    (pde_frame_q),
    .leaf_frame   (ent_q[ENTRY_W-1 -: FRAME_W]),
    .dir_ent_addr (dir_ent_addr),
    .tbl_ent_addr (tbl_ent_addr),
    .leaf_phys    (leaf_phys)
  );

  // One entry evaluator per level; level 1 is the final one
  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    pgwalk_entry #(.ENTRY_W(ENTRY_W), .LEAF(lv == NUM_LVL - 1)) u_entry (
      .ent      (ent_q),
      .is_write (wr_q),
      .present  (present[lv]),
      .wb_need  (wb_need[lv]),
      .wb_data  (wb_data[lv])
    );
  end

  // ---------------- assertions ----------------
  logic [ADDR_W-1:0] last_rd_addr_q;
  always_ff @(posedge clk) begin
    if (mem_req_valid && mem_req_ready && !mem_req_we) last_rd_addr_q <= mem_req_addr;
  end

  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_int_n) // R9
    mem_req_valid && mem_req_we |-> mem_req_addr == last_rd_addr_q);

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_int_n) // R7
    mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_ACCESSED] && mem_req_wdata[BIT_PRESENT]);

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_int_n) // R11
    req_ready |-> !mem_req_valid);

  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_int_n) // R11
    !rsp_done |-> !rsp_fault);

endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, pg_enable;
  logic [31:0] req_lin, dir_base;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_phys;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .pg_enable(pg_enable), .dir_base(dir_base),
    .rsp_done(rsp_done), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  logic [31:0] mem [logic [31:0]];
  logic [64:0] expq [$];
  string       tagq [$];
  logic [31:0] exp_phys;
  logic        exp_fault;
  string       exp_tag;
  logic        busy, done_seen, checking;
  int          checks = 0, fails = 0, cyc = 0, pend = 0, lat = 1, stall_mode = 0;
  logic [31:0] pend_addr;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Behavioural model: expected memory operations and result of one lookup
  task automatic model(input logic [31:0] lin, input logic wr, input logic pg);
    logic [31:0] pa, ta, pde, pte, np;
    expq.delete(); tagq.delete();
    exp_fault = 1'b0;
    if (!pg) begin exp_phys = lin; exp_tag = "R1"; return; end
    pa = {dir_base[31:12], lin[31:22], 2'b00};
    expq.push_back({1'b0, pa, 32'h0}); tagq.push_back("R2");
    pde = rd(pa);
    if (!pde[0]) begin exp_fault = 1'b1; exp_phys = 32'h0; exp_tag = "R5"; return; end
    if (!pde[5]) begin expq.push_back({1'b1, pa, pde | 32'h20}); tagq.push_back("R7"); end
    ta = {pde[31:12], lin[21:12], 2'b00};
    expq.push_back({1'b0, ta, 32'h0}); tagq.push_back("R3");
    pte = rd(ta);
    if (!pte[0]) begin exp_fault = 1'b1; exp_phys = 32'h0; exp_tag = "R6"; return; end
    np = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (np != pte) begin expq.push_back({1'b1, ta, np}); tagq.push_back("R8"); end
    exp_phys = {pte[31:12], lin[11:0]};
    exp_tag  = "R4";
  endtask

  // One cycle: memory responder and per-cycle comparison, at the falling edge
  task automatic step();
    logic [64:0] e;
    string t;
    @(negedge clk);
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin mem_rsp_valid = 1'b1; mem_rsp_rdata = rd(pend_addr); end
    end
    case (stall_mode)
      0:       mem_req_ready = 1'b1;
      1:       mem_req_ready = (cyc % 3 == 0);
      default: mem_req_ready = (cyc % 2 == 0);
    endcase
    if (checking) begin
      check(req_ready === !busy, "R11", "req_ready against busy", req_ready, !busy);
      if (!rsp_done && rsp_fault) check(1'b0, "R11", "fault without done", rsp_fault, 0);
      if (mem_req_valid && !busy) check(1'b0, "R11", "memory request while idle", mem_req_addr, 0);
      if (mem_req_valid && mem_req_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected memory request", {mem_req_we, mem_req_addr}, 0);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          check(mem_req_we === e[64] && mem_req_addr === e[63:32] &&
                (!e[64] || mem_req_wdata === e[31:0]), t,
                $sformatf("memory op we=%0b exp_we=%0b {addr,wdata}", mem_req_we, e[64]),
                {mem_req_addr, mem_req_wdata}, e[63:0]);
        end
        if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
        else begin pend = lat; pend_addr = mem_req_addr; end
      end
      if (rsp_done) begin
        if (!busy) check(1'b0, "R11", "done while idle", rsp_done, 0);
        else begin
          check(rsp_fault === exp_fault, exp_tag, "fault flag", rsp_fault, exp_fault);
          check(rsp_phys === exp_phys, exp_tag, "physical address", rsp_phys, exp_phys);
          check(expq.size() == 0, "R9", "memory ops still outstanding at done", expq.size(), 0);
          busy = 1'b0;
          done_seen = 1'b1;
        end
      end
    end
  endtask

  task automatic walk(input logic [31:0] lin, input logic wr, input logic pg,
                      input logic [31:0] base, input int lt, input int sm);
    int n;
    lat = lt; stall_mode = sm;
    n = 0;
    while (!req_ready && n < 50) begin step(); n++; end
    dir_base  = base;
    req_valid = 1'b1; req_lin = lin; req_write = wr; pg_enable = pg;
    model(lin, wr, pg);
    busy = 1'b1; done_seen = 1'b0;
    step();
    // change inputs after acceptance: they must have no effect (R2)
    req_valid = 1'b0; req_lin = 32'hFFFF_FFFF; req_write = !wr; pg_enable = !pg;
    dir_base  = 32'hDEAD_B000;
    if (!pg) check(done_seen, "R1", "bypass done one cycle after accept", done_seen, 1);
    n = 1;
    while (!done_seen && n < 300) begin step(); n++; end
    if (!done_seen) begin
      check(1'b0, "R10", "walk never finished", n, 300);
      busy = 1'b0;
    end
    step();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R10 global watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_lin = '0; req_write = 1'b0; pg_enable = 1'b0;
    dir_base = 32'h0010_0000; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0; busy = 1'b0; done_seen = 1'b0; checking = 1'b0;

    mem[32'h0010_0004] = 32'h0020_0001;  // dir 1, A clear
    mem[32'h0020_000C] = 32'h1234_5003;
    mem[32'h0020_0014] = 32'h0ABC_D001;  // A and D clear
    mem[32'h0020_0018] = 32'h0002_2041;  // D set, A clear
    mem[32'h0010_0008] = 32'h5555_5574;  // not present, junk bits
    mem[32'h0010_000C] = 32'h0030_0041;  // dir D set, A clear
    mem[32'h0030_0004] = 32'h7777_7000;  // not present
    mem[32'h0010_0010] = 32'h0040_0003;  // dir A, D clear
    mem[32'h0040_0000] = 32'h0000_9001;
    mem[32'h0800_0000] = 32'h0040_0021;  // second directory
    mem[32'h0010_0FFC] = 32'h0050_0021;
    mem[32'h0050_0FFC] = 32'hFFFF_F021;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    checking = 1'b1;
    check(req_ready === 1'b1, "R11", "reset: req_ready", req_ready, 1);
    check(mem_req_valid === 1'b0, "R11", "reset: mem_req_valid", mem_req_valid, 0);
    check(rsp_done === 1'b0, "R11", "reset: rsp_done", rsp_done, 0);

    walk(32'h0040_3ABC, 1'b0, 1'b1, 32'h0010_0000, 1, 0); // R7 R8 both levels updated
    walk(32'h0040_3ABC, 1'b0, 1'b1, 32'h0010_0000, 2, 1); // R9 no write-backs
    walk(32'h0040_3000, 1'b1, 1'b1, 32'h0010_0000, 1, 2); // R8 dirty only
    walk(32'h0040_5010, 1'b1, 1'b1, 32'h0010_0000, 3, 1); // R8 A and D in one write
    walk(32'h0080_0000, 1'b1, 1'b1, 32'h0010_0000, 1, 0); // R5
    walk(32'h00C0_1234, 1'b1, 1'b1, 32'h0010_0000, 2, 2); // R6 R7 dir D kept
    walk(32'h0100_0008, 1'b1, 1'b1, 32'h0010_0000, 1, 1); // R7 dir D stays clear
    walk(32'hCAFE_F00D, 1'b1, 1'b0, 32'h0010_0000, 1, 0); // R1
    walk(32'h0000_0000, 1'b0, 1'b0, 32'h0010_0000, 1, 2); // R1
    walk(32'h0000_0FFF, 1'b0, 1'b1, 32'h0800_0000, 2, 0); // R2 other base, R4
    walk(32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0010_0000, 1, 2); // R3 top indices
    walk(32'h0040_6000, 1'b0, 1'b1, 32'h0010_0000, 3, 2); // R8 keep D on read

    // memory state after the walks (R7: dir D untouched; R6: faulting entry untouched)
    check(mem[32'h0010_000C] === 32'h0030_0061, "R7", "dir entry after write walk", mem[32'h0010_000C], 32'h0030_0061);
    check(mem[32'h0010_0010] === 32'h0040_0023, "R7", "dir D stays clear", mem[32'h0010_0010], 32'h0040_0023);
    check(mem[32'h0030_0004] === 32'h7777_7000, "R6", "not-present entry unchanged", mem[32'h0030_0004], 32'h7777_7000);
    check(mem[32'h0010_0008] === 32'h5555_5574, "R5", "not-present dir entry unchanged", mem[32'h0010_0008], 32'h5555_5574);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule